// File: doc/BRIEF.md
# USB FIFO to Parallel Configuration Bridge

This block connects a synchronous byte-wide USB FIFO bridge to the parallel configuration port of a target FPGA. A two-bit mode input chooses what happens to each byte that the host sends.

In data mode, each byte is placed on an 8-bit configuration data bus and framed by one pulse of a generated configuration clock. In command mode, the byte is loaded into a small control register. That register drives the target's program line and its active-low reset.

In the return direction, the block sends a four-byte status frame on a fixed period without waiting for a request. The frame reports the target's done and init pins, an address strap and a board revision strap. A combined done output rises only when both target pins are high. The block is used by driving the program line through command bytes, streaming the bitstream in data mode, and then watching the status frames.

Top module: `usb_cfg_bridge`

## Requirements
- R1: While `rstN` is low and just after it rises, `progN`, `tgtResetN`, `cfgClk` and `cfgDone` are 0 and `oeN`, `rdN` and `wrN` are 1.
- R2: With `modeIn` = 2'b00, every byte read from the FIFO appears on `cfgData` in FIFO order. `cfgClk` stays low for HALF_CYCLES clocks and then high for HALF_CYCLES clocks while that byte is held, so the rising edge falls in the middle of the byte.
- R3: A read is one cycle of `rdN` low, preceded by one cycle with `oeN` low. No read occurs while a byte is being clocked out, so back-to-back data reads are exactly 2*HALF_CYCLES+3 cycles apart.
- R4: With `modeIn` = 2'b01 (bit 0 set, bit 1 clear), a byte read from the FIFO is loaded into the control register and produces no `cfgClk` pulse.
- R5: Control register bit 0 drives `progN` and bit 1 drives `tgtResetN`.
- R6: With `modeIn` = 2'b10 or 2'b11, the block reads nothing from the FIFO. Pending bytes stay in it.
- R7: `modeIn` passes through two flops and is taken only when a byte transfer starts. A mode change made while a byte is in flight applies to the next byte.
- R8: A status frame starts every STATUS_PERIOD cycles. Its bytes are 8'hA5, 8'h5A, the status byte, then 8'h00, in that order.
- R9: Status byte bits: bit 0 = done pin, bit 1 = init pin, bit 4 = address strap open (1) or grounded (0), bit 5 = newer board revision. All other bits are 0.
- R10: A frame byte is written only in a cycle where `txRoomN` is low. If `txRoomN` goes high partway through a frame, the frame pauses and then resumes at the next unsent byte.
- R11: `cfgDone` is high exactly when the synchronized done and init inputs are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO clock |
| rstN | input | 1 | Active-low reset |
| modeIn | input | 2 | Path select (00 data, 01 command, others idle) |
| rxReadyN | input | 1 | Low while the FIFO holds a received byte |
| fifoDin | input | 8 | Received byte from the FIFO |
| oeN | output | 1 | FIFO output enable, active low |
| rdN | output | 1 | FIFO read strobe, active low |
| txRoomN | input | 1 | Low while the FIFO can accept a byte |
| wrN | output | 1 | FIFO write strobe, active low |
| fifoDout | output | 8 | Byte sent toward the host |
| cfgData | output | 8 | Configuration data bus |
| cfgClk | output | 1 | Configuration clock |
| progN | output | 1 | Target program line |
| tgtResetN | output | 1 | Target reset, active low |
| confDoneIn | input | 1 | Target done pin |
| initDoneIn | input | 1 | Target init pin |
| strapOpen | input | 1 | Address strap, 1 when unconnected |
| boardRevNew | input | 1 | Board revision strap |
| cfgDone | output | 1 | Done and init both high |

## Verification
A data byte is read two cycles after the block leaves idle. Its `cfgClk` rise comes HALF_CYCLES+1 cycles after the read, and the next read follows 2*HALF_CYCLES+3 cycles after it. The bench records bytes on the `cfgClk` rising edge and measures read spacing in clock cycles, so neither result depends on a fixed sampling delay.

Control register and `cfgDone` changes are checked after waits longer than their one- or two-flop paths. Status frames are captured byte by byte at each accepted write. Each strap pattern is checked on the second frame after it changes, because only that frame's snapshot is guaranteed to follow the two-flop synchronizer.

// File: rtl/usb_cfg_bridge_pkg.sv
package usb_cfg_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_READ,
    ST_CLKLO,
    ST_CLKHI
  } rdState_t;

  localparam logic [1:0] MODE_DATA = 2'b00;
  localparam logic [1:0] MODE_CMD  = 2'b01;

  localparam logic [7:0] HDR_FIRST  = 8'hA5;
  localparam logic [7:0] HDR_SECOND = 8'h5A;
  localparam logic [7:0] FRAME_PAD  = 8'h00;

  typedef struct packed {
    logic       captureData;
    logic       captureCmd;
    logic       snapStatus;
    logic [1:0] frameIdx;
  } strobes_t;

  function automatic logic [7:0] frameByte(input logic [1:0] idx, input logic [7:0] status);
    case (idx)
      2'd0:    frameByte = HDR_FIRST;
      2'd1:    frameByte = HDR_SECOND;
      2'd2:    frameByte = status;
      default: frameByte = FRAME_PAD;
    endcase
  endfunction

endpackage

// File: rtl/usb_cfg_bridge_ctrl.sv
module usb_cfg_bridge_ctrl
  import usb_cfg_bridge_pkg::*;
#(
  parameter int HALF_CYCLES   = 2,
  parameter int STATUS_PERIOD = 6000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeIn,
  input  logic       rxReadyN,
  input  logic       txRoomN,
  output logic       oeN,
  output logic       rdN,
  output logic       wrN,
  output logic       cfgClk,
  output strobes_t   strb
);
  localparam int HW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int PW = (STATUS_PERIOD > 1) ? $clog2(STATUS_PERIOD) : 1;
  localparam logic [HW-1:0] HALF_LAST = HW'(HALF_CYCLES - 1);
  localparam logic [PW-1:0] PERIOD_LAST = PW'(STATUS_PERIOD - 1);

  logic [1:0] modeMeta, modeSync;
  rdState_t   state;
  logic       isCmd;
  logic [HW-1:0] halfCnt;
  logic [PW-1:0] periodCnt;
  logic       sending;
  logic [1:0] frameIdx;
  logic       modeData, modeCmd, periodHit;

  assign modeData  = (modeSync == MODE_DATA);
  assign modeCmd   = (modeSync == MODE_CMD);
  assign periodHit = (periodCnt == PERIOD_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeMeta <= '0;
      modeSync <= '0;
    end else begin
      modeMeta <= modeIn;
      modeSync <= modeMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isCmd   <= 1'b0;
      halfCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (!rxReadyN && (modeData || modeCmd)) begin
          isCmd <= modeCmd;
          state <= ST_OPEN;
        end
        ST_OPEN: state <= ST_READ;
        ST_READ: begin
          if (!rxReadyN && !isCmd) begin
            state   <= ST_CLKLO;
            halfCnt <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_CLKLO: begin
          if (halfCnt == HALF_LAST) begin
            halfCnt <= '0;
            state   <= ST_CLKHI;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_CLKHI: begin
          if (halfCnt == HALF_LAST) begin
            halfCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
      sending   <= 1'b0;
      frameIdx  <= '0;
    end else begin
      periodCnt <= periodHit ? '0 : periodCnt + 1'b1;
      if (sending && !txRoomN) begin
        if (frameIdx == 2'd3) sending <= 1'b0;
        frameIdx <= frameIdx + 1'b1;
      end
      if (periodHit && !sending) begin
        sending  <= 1'b1;
        frameIdx <= '0;
      end
    end
  end

  assign oeN    = !((state == ST_OPEN) || (state == ST_READ));
  assign rdN    = !(state == ST_READ);
  assign cfgClk = (state == ST_CLKHI);
  assign wrN    = !(sending && !txRoomN);

  always_comb begin
    strb.captureData = (state == ST_READ) && !rxReadyN && !isCmd;
    strb.captureCmd  = (state == ST_READ) && !rxReadyN && isCmd;
    strb.snapStatus  = periodHit && !sending;
    strb.frameIdx    = frameIdx;
  end

  // R3
  rd_single_chk: assert property (@(posedge clk) disable iff (!rstN) !rdN |=> rdN);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(isCmd));

  // R10
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sending && txRoomN) |=> $stable(frameIdx));

  // R8
  frame_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrN && frameIdx == 2'd3) |=> !sending);

endmodule

// File: rtl/usb_cfg_bridge_datapath.sv
module usb_cfg_bridge_datapath
  import usb_cfg_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobes_t   strb,
  input  logic [7:0] fifoDin,
  input  logic       confDoneIn,
  input  logic       initDoneIn,
  input  logic       strapOpen,
  input  logic       boardRevNew,
  output logic [7:0] cfgData,
  output logic [7:0] fifoDout,
  output logic       progN,
  output logic       tgtResetN,
  output logic       cfgDone
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] pinsRaw, pinsMeta, pinsSync;
  logic [7:0] dataReg, statusReg;
  logic [1:0] ctrlReg;

  assign pinsRaw = {boardRevNew, strapOpen, initDoneIn, confDoneIn};

  for (genvar g = 0; g < NSYNC; g++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinsMeta[g] <= 1'b0;
        pinsSync[g] <= 1'b0;
      end else begin
        pinsMeta[g] <= pinsRaw[g];
        pinsSync[g] <= pinsMeta[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg   <= '0;
      ctrlReg   <= '0;
      statusReg <= '0;
    end else begin
      if (strb.captureData) dataReg <= fifoDin;
      if (strb.captureCmd)  ctrlReg <= fifoDin[1:0];
      if (strb.snapStatus)
        statusReg <= {2'b00, pinsSync[3], pinsSync[2], 2'b00, pinsSync[1], pinsSync[0]};
    end
  end

  assign cfgData   = dataReg;
  assign progN     = ctrlReg[0];
  assign tgtResetN = ctrlReg[1];
  assign cfgDone   = pinsSync[0] & pinsSync[1];
  assign fifoDout  = frameByte(strb.frameIdx, statusReg);

  // R2
  cfg_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureData |=> $stable(cfgData));

  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureCmd |=> $stable({progN, tgtResetN}));

endmodule

// File: rtl/usb_cfg_bridge.sv
module usb_cfg_bridge
  import usb_cfg_bridge_pkg::*;
#(
  parameter int HALF_CYCLES   = 2,
  parameter int STATUS_PERIOD = 6000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeIn,
  input  logic       rxReadyN,
  input  logic [7:0] fifoDin,
  output logic       oeN,
  output logic       rdN,
  input  logic       txRoomN,
  output logic       wrN,
  output logic [7:0] fifoDout,
  output logic [7:0] cfgData,
  output logic       cfgClk,
  output logic       progN,
  output logic       tgtResetN,
  input  logic       confDoneIn,
  input  logic       initDoneIn,
  input  logic       strapOpen,
  input  logic       boardRevNew,
  output logic       cfgDone
);
  strobes_t strb;

  usb_cfg_bridge_ctrl #(
    .HALF_CYCLES(HALF_CYCLES),
    .STATUS_PERIOD(STATUS_PERIOD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .rxReadyN(rxReadyN),
    .txRoomN(txRoomN), .oeN(oeN), .rdN(rdN), .wrN(wrN),
    .cfgClk(cfgClk), .strb(strb)
  );

  usb_cfg_bridge_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fifoDin(fifoDin),
    .confDoneIn(confDoneIn), .initDoneIn(initDoneIn),
    .strapOpen(strapOpen), .boardRevNew(boardRevNew),
    .cfgData(cfgData), .fifoDout(fifoDout), .progN(progN),
    .tgtResetN(tgtResetN), .cfgDone(cfgDone)
  );

endmodule

// File: tb/usb_cfg_bridge_bench.sv
module usb_cfg_bridge_bench;
  localparam int HALF = 2;
  localparam int PERIOD = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeIn = 2'b11;
  logic rxReadyN;
  logic [7:0] fifoDin;
  logic oeN, rdN, wrN, cfgClk, progN, tgtResetN, cfgDone;
  logic txRoomN = 1'b1;
  logic [7:0] fifoDout, cfgData;
  logic confDoneIn = 1'b0, initDoneIn = 1'b0, strapOpen = 1'b0, boardRevNew = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [7:0] fifoMem [0:511];
  int wrPtr = 0;
  int rdPtr = 0;
  logic [7:0] rxLog [0:511];
  int rxCnt = 0;
  logic [7:0] txLog [0:1023];
  int txTime [0:1023];
  int txCnt = 0;
  int lastRd = -1;
  int minGap = 1000;

  always #10 clk = ~clk;

  usb_cfg_bridge #(.HALF_CYCLES(HALF), .STATUS_PERIOD(PERIOD)) u_usb_cfg_bridge (
    .clk(clk), .rstN(rstN), .modeIn(modeIn), .rxReadyN(rxReadyN), .fifoDin(fifoDin),
    .oeN(oeN), .rdN(rdN), .txRoomN(txRoomN), .wrN(wrN), .fifoDout(fifoDout),
    .cfgData(cfgData), .cfgClk(cfgClk), .progN(progN), .tgtResetN(tgtResetN),
    .confDoneIn(confDoneIn), .initDoneIn(initDoneIn), .strapOpen(strapOpen),
    .boardRevNew(boardRevNew), .cfgDone(cfgDone)
  );

  assign rxReadyN = !(rdPtr < wrPtr);
  assign fifoDin  = fifoMem[rdPtr % 512];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rdN && !rxReadyN) rdPtr <= rdPtr + 1;
    if (!rdN) begin
      if (lastRd >= 0 && (cyc - lastRd) < minGap) minGap <= cyc - lastRd;
      lastRd <= cyc;
    end
    if (!wrN && !txRoomN && txCnt < 1024) begin
      txLog[txCnt]  <= fifoDout;
      txTime[txCnt] <= cyc;
      txCnt <= txCnt + 1;
    end
  end

  always @(posedge cfgClk) begin
    if (rxCnt < 512) rxLog[rxCnt] <= cfgData;
    rxCnt <= rxCnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    fifoMem[wrPtr % 512] = b;
    wrPtr++;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkFrame(input int base, input logic [7:0] st, input string req);
    check(txLog[base] == 8'hA5, req, txLog[base], 8'hA5);
    check(txLog[base+1] == 8'h5A, req, txLog[base+1], 8'h5A);
    check(txLog[base+2] == st, req, txLog[base+2], st);
    check(txLog[base+3] == 8'h00, req, txLog[base+3], 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    int rx0;
    logic [7:0] st;
    waitCycles(4);
    // R1 reset state while held
    check(progN == 0 && tgtResetN == 0 && cfgClk == 0 && cfgDone == 0, "R1", {progN, tgtResetN, cfgClk, cfgDone}, 0);
    check(oeN && rdN && wrN, "R1", {oeN, rdN, wrN}, 3'b111);
    rstN = 1'b1;
    waitCycles(2);
    check(progN == 0 && tgtResetN == 0 && cfgClk == 0, "R1", {progN, tgtResetN, cfgClk}, 0);

    // R2/R3 data stream sweep over all byte values
    modeIn = 2'b00;
    waitCycles(3);
    for (int i = 0; i < 256; i++) push(8'(i));
    while (rdPtr < 256) @(negedge clk);
    waitCycles(10);
    check(rxCnt == 256, "R2", rxCnt, 256);
    for (int i = 0; i < 256; i++) check(rxLog[i] == 8'(i), "R2", rxLog[i], i);
    check(minGap == 2 * HALF + 3, "R3", minGap, 2 * HALF + 3);

    // R6 idle modes leave FIFO untouched
    modeIn = 2'b10;
    waitCycles(3);
    push(8'h77);
    waitCycles(30);
    check(rdPtr == wrPtr - 1 && rdN, "R6", rdPtr, wrPtr - 1);
    modeIn = 2'b11;
    waitCycles(30);
    check(rdPtr == wrPtr - 1 && rxCnt == 256, "R6", rdPtr, wrPtr - 1);

    // R4/R5 command mode
    modeIn = 2'b01;
    waitCycles(20);
    check(rdPtr == wrPtr, "R4", rdPtr, wrPtr);
    check(rxCnt == 256, "R4", rxCnt, 256);
    check(progN == 1 && tgtResetN == 1, "R5", {tgtResetN, progN}, 2'b11);
    push(8'h02);
    waitCycles(10);
    check(progN == 0 && tgtResetN == 1, "R5", {tgtResetN, progN}, 2'b10);
    push(8'h01);
    waitCycles(10);
    check(progN == 1 && tgtResetN == 0, "R5", {tgtResetN, progN}, 2'b01);
    check(rxCnt == 256, "R4", rxCnt, 256);

    // R7 mode change while a data byte is in flight
    modeIn = 2'b00;
    waitCycles(4);
    rx0 = rxCnt;
    push(8'hC3);
    while (rdPtr < wrPtr) @(negedge clk);
    modeIn = 2'b01;
    push(8'h02);
    waitCycles(30);
    check(rxCnt == rx0 + 1, "R7", rxCnt, rx0 + 1);
    check(rxLog[rx0] == 8'hC3, "R7", rxLog[rx0], 8'hC3);
    check(progN == 0 && tgtResetN == 1, "R7", {tgtResetN, progN}, 2'b10);

    // R11 combined done
    for (int k = 0; k < 4; k++) begin
      confDoneIn = k[0];
      initDoneIn = k[1];
      waitCycles(4);
      check(cfgDone == (k == 3), "R11", cfgDone, k == 3);
    end

    // R10 nothing written while no room
    check(txCnt == 0 && wrN, "R10", txCnt, 0);

    // R8/R9 status sweep over all strap and pin combinations
    txRoomN = 1'b0;
    while (txCnt < 4) @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      while (txCnt % 4 != 0) @(negedge clk);
      base = txCnt;
      confDoneIn  = k[0];
      initDoneIn  = k[1];
      strapOpen   = k[2];
      boardRevNew = k[3];
      st = {2'b00, boardRevNew, strapOpen, 2'b00, initDoneIn, confDoneIn};
      while (txCnt < base + 8) @(negedge clk);
      checkFrame(base + 4, st, "R9");
      if (k == 5) check(txTime[base + 4] - txTime[base] == PERIOD, "R8",
                        txTime[base + 4] - txTime[base], PERIOD);
    end

    // R10 pause mid-frame and resume
    while (txCnt % 4 != 0) @(negedge clk);
    base = txCnt;
    while (txCnt < base + 2) @(negedge clk);
    txRoomN = 1'b1;
    waitCycles(20);
    check(txCnt == base + 2 && wrN, "R10", txCnt, base + 2);
    txRoomN = 1'b0;
    while (txCnt < base + 4) @(negedge clk);
    checkFrame(base, st, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule